// File: doc/BRIEF.md
# Shift Accumulator with Bus Zero Detect

This block is the operand side of a small 8-bit datapath. It holds two registers. The shift register H feeds the arithmetic unit and can also serve as a general register. The accumulator A is visible to the program and is not connected to the arithmetic unit. Microcode steers H with a two-bit mode and a carry-in select. H can keep its value, take the bus value in parallel, or move one place left or right. The bit that enters H during a shift is either zero or the stored carry flag.

Every write to A places the same bus value in H, so the two registers agree at the end of each instruction. Between those writes, memory operations such as increment, decrement and shift can work in H and leave A untouched. The bit that leaves H during a shift appears on a separate output, so an external carry register can capture it for rotates. A zero detector watches the data bus and captures the result into the Z flag when a strobe is given. Plain register loads and transfers can therefore update Z.

Top module: `shift_acc`

## Requirements
- R1: While rst_n is low, h_q, a_q and z_flag are all 0.
- R2: With h_mode = 00 and a_wr low, H keeps its value across the clock edge.
- R3: With h_mode = 11 and a_wr low, H takes bus_in on the clock edge.
- R4: With h_mode = 01 and a_wr low, H moves one place toward bit 0 on the clock edge, and the incoming bit enters bit 7.
- R5: With h_mode = 10 and a_wr low, H moves one place toward bit 7 on the clock edge, and the incoming bit enters bit 0.
- R6: The incoming shift bit is 0 when cin_sel = 0 and equals carry_in when cin_sel = 1.
- R7: shift_out is combinational. It equals H bit 7 when h_mode = 10 and H bit 0 when h_mode = 01, and it is 0 for the other two modes. a_wr does not change it.
- R8: When a_wr is high, both A and H take bus_in on the clock edge, whatever h_mode is.
- R9: When a_wr is low, A keeps its value, whatever H does.
- R10: When z_upd is high, z_flag takes 1 on the clock edge if all eight bits of bus_in are 0, and 0 otherwise. When z_upd is low, z_flag holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_in | input | 8 | Data bus value |
| h_mode | input | 2 | H mode: 00 hold, 01 shift right, 10 shift left, 11 load |
| cin_sel | input | 1 | Shift-in source: 0 gives zero, 1 gives carry_in |
| carry_in | input | 1 | Stored carry flag |
| a_wr | input | 1 | Write the bus into A and H |
| z_upd | input | 1 | Capture the bus zero test into Z |
| h_q | output | 8 | Shift register H |
| a_q | output | 8 | Accumulator A |
| shift_out | output | 1 | Bit leaving H in the current shift mode |
| z_flag | output | 1 | Zero flag |

## Verification
The bench applies a_wr together with a shift mode. A design that let the mode win would leave H and A different after an accumulator write. It shifts with each carry-in source and with carry_in held against the selected value, which exposes a swapped or ignored select and a shift that enters the wrong end. It runs long sequences of H loads and shifts with a_wr low, which catches any leak into A. It also checks shift_out while a_wr is high, when a shift_out taken from the load path would go wrong. Z is driven with a zero bus while the strobe is low and with nonzero buses while the strobe is high, which catches a flag that follows the bus freely or tests only part of it.

// File: rtl/shift_acc_pkg.sv
package shift_acc_pkg;
    typedef enum logic [1:0] {
        HM_HOLD = 2'b00,
        HM_SHR  = 2'b01,
        HM_SHL  = 2'b10,
        HM_LOAD = 2'b11
    } hmode_e;
endpackage

// File: rtl/shift_acc_hreg.sv
module shift_acc_hreg
    import shift_acc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  hmode_e       mode,
    input  logic         force_ld,
    input  logic [W-1:0] din,
    input  logic         ser_in,
    output logic [W-1:0] h_q,
    output logic         ser_out
);
    typedef struct packed {
        logic [W-1:0] h;
    } hst_t;

    hst_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        ser_out = 1'b0;
        unique case (mode)
            HM_HOLD: st_d.h = st_q.h;
            HM_SHR: begin
                st_d.h  = {ser_in, st_q.h[W-1:1]};
                ser_out = st_q.h[0];
            end
            HM_SHL: begin
                st_d.h  = {st_q.h[W-2:0], ser_in};
                ser_out = st_q.h[W-1];
            end
            HM_LOAD: st_d.h = din;
            default: st_d.h = st_q.h;
        endcase
        if (force_ld) begin
            st_d.h = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign h_q = st_q.h;

    assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == HM_HOLD && !force_ld) |=> $stable(h_q));
    assert_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == HM_LOAD && !force_ld) |=> h_q == $past(din));
    assert_shr_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == HM_SHR && !force_ld) |=> h_q == {$past(ser_in), $past(h_q[W-1:1])});
    assert_shl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == HM_SHL && !force_ld) |=> h_q == {$past(h_q[W-2:0]), $past(ser_in)});
endmodule

// File: rtl/shift_acc_areg.sv
module shift_acc_areg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         we,
    input  logic [W-1:0] din,
    output logic [W-1:0] a_q
);
    typedef struct packed {
        logic [W-1:0] a;
    } ast_t;

    ast_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (we) begin
            st_d.a = din;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign a_q = st_q.a;

    assert_a_keep_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !we |=> $stable(a_q));
endmodule

// File: rtl/shift_acc_zdet.sv
module shift_acc_zdet #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         upd,
    input  logic [W-1:0] bus,
    output logic         z_q
);
    typedef struct packed {
        logic z;
    } zst_t;

    zst_t st_d, st_q;
    logic bus_zero;

    always_comb begin
        bus_zero = ~(|bus);
        st_d     = st_q;
        if (upd) begin
            st_d.z = bus_zero;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign z_q = st_q.z;

    assert_z_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> z_q == ($past(bus) == '0));
    assert_z_keep_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(z_q));
endmodule

// File: rtl/shift_acc.sv
module shift_acc
    import shift_acc_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] bus_in,
    input  logic [1:0]   h_mode,
    input  logic         cin_sel,
    input  logic         carry_in,
    input  logic         a_wr,
    input  logic         z_upd,
    output logic [W-1:0] h_q,
    output logic [W-1:0] a_q,
    output logic         shift_out,
    output logic         z_flag
);
    logic   shin;
    hmode_e mode;

    always_comb begin
        mode = hmode_e'(h_mode);
        shin = cin_sel ? carry_in : 1'b0;
    end

    shift_acc_hreg #(.W(W)) u_h (
        .clk(clk), .rst_n(rst_n), .mode(mode), .force_ld(a_wr),
        .din(bus_in), .ser_in(shin), .h_q(h_q), .ser_out(shift_out)
    );

    shift_acc_areg #(.W(W)) u_a (
        .clk(clk), .rst_n(rst_n), .we(a_wr), .din(bus_in), .a_q(a_q)
    );

    shift_acc_zdet #(.W(W)) u_z (
        .clk(clk), .rst_n(rst_n), .upd(z_upd), .bus(bus_in), .z_q(z_flag)
    );

    assert_shadow_R8: assert property (@(posedge clk) disable iff (!rst_n)
        a_wr |=> (h_q == a_q) && (a_q == $past(bus_in)));
    assert_zero_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!a_wr && !cin_sel && h_mode == 2'b10) |=> h_q[0] == 1'b0);
    assert_sout_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (h_mode == 2'b00 || h_mode == 2'b11) |-> !shift_out);
endmodule

// File: tb/sim_shift_acc.sv
`timescale 1ns/1ps
module sim_shift_acc;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [7:0] bus_in = 8'h00;
    logic [1:0] h_mode = 2'b00;
    logic       cin_sel = 1'b0, carry_in = 1'b0, a_wr = 1'b0, z_upd = 1'b0;
    logic [7:0] h_q, a_q;
    logic       shift_out, z_flag;

    int checks = 0, fails = 0;
    bit done = 0;
    logic [7:0] m_h = 8'h00, m_a = 8'h00;
    logic       m_z = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #4 clk = ~clk;

    shift_acc u0 (
        .clk(clk), .rst_n(rst_n), .bus_in(bus_in), .h_mode(h_mode),
        .cin_sel(cin_sel), .carry_in(carry_in), .a_wr(a_wr), .z_upd(z_upd),
        .h_q(h_q), .a_q(a_q), .shift_out(shift_out), .z_flag(z_flag)
    );

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    function automatic string htag();
        if (a_wr) return "R8";
        case (h_mode)
            2'b11:   return "R3";
            2'b01:   return cin_sel ? "R6" : "R4";
            2'b10:   return cin_sel ? "R6" : "R5";
            default: return "R2";
        endcase
    endfunction

    logic last_awr = 1'b0;

    task automatic step(input logic [1:0] md, input logic cs, input logic ci,
                        input logic aw, input logic zu, input logic [7:0] b);
        string t;
        logic  so;
        @(negedge clk);
        t = htag();
        chk(t, h_q, m_h);
        chk(last_awr ? "R8" : "R9", a_q, m_a);
        chk("R10", {7'd0, z_flag}, {7'd0, m_z});
        h_mode = md; cin_sel = cs; carry_in = ci; a_wr = aw; z_upd = zu; bus_in = b;
        #1;
        so = (md == 2'b10) ? m_h[7] : (md == 2'b01) ? m_h[0] : 1'b0;
        chk("R7", {7'd0, shift_out}, {7'd0, so});
        @(posedge clk);
        begin
            logic inb;
            inb = cs ? ci : 1'b0;
            if (aw) begin
                m_h = b; m_a = b;
            end else begin
                case (md)
                    2'b01: m_h = {inb, m_h[7:1]};
                    2'b10: m_h = {m_h[6:0], inb};
                    2'b11: m_h = b;
                    default: ;
                endcase
            end
            if (zu) m_z = (b == 8'h00);
            last_awr = aw;
        end
    endtask

    initial begin
        #(8 * 150000);
        checks++; fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        bus_in = 8'h5A; a_wr = 1'b1; h_mode = 2'b11; z_upd = 1'b1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk("R1", h_q, 8'h00);
        chk("R1", a_q, 8'h00);
        chk("R1", {7'd0, z_flag}, 8'h00);
        a_wr = 1'b0; h_mode = 2'b00; z_upd = 1'b0;
        rst_n = 1'b1;
        step(2'b00, 0, 0, 1, 0, 8'hA5);  // R8 write A and H
        step(2'b00, 0, 1, 0, 0, 8'hFF);  // R2 hold
        step(2'b10, 0, 1, 0, 0, 8'h00);  // R5 shl, zero in despite carry_in
        step(2'b10, 1, 1, 0, 0, 8'h00);  // R6 shl with carry
        step(2'b01, 1, 1, 0, 0, 8'h00);  // R4/R6 shr with carry
        step(2'b01, 0, 1, 0, 0, 8'h00);  // R4 shr zero in
        step(2'b11, 0, 0, 0, 0, 8'h3C);  // R3 load, A stays (R9)
        step(2'b01, 0, 0, 1, 0, 8'h81);  // R8 a_wr overrides shift, R7 shift_out
        step(2'b10, 0, 0, 1, 1, 8'h00);  // R8 override with shl, R10 zero bus
        step(2'b00, 0, 0, 0, 0, 8'h00);  // R10 hold with zero bus
        step(2'b00, 0, 0, 0, 1, 8'h80);  // R10 top bit only
        step(2'b00, 0, 0, 0, 1, 8'h00);
        step(2'b00, 0, 0, 0, 1, 8'h01);  // R10 low bit only
        step(2'b00, 0, 0, 0, 0, 8'hFF);
        for (int i = 0; i < 2000; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            step(lfsr[1:0], lfsr[2], lfsr[3], (lfsr[7:4] == 4'h0), lfsr[8], lfsr[15:8]);
        end
        step(2'b00, 0, 0, 0, 0, 8'h00);
        finish_run();
    end
endmodule